// File: doc/BRIEF.md
# Retransmission Timer and Replay Attempt Supervisor

This block watches the transmit side of a reliable link layer. It does not hold the packets themselves. A cycle-based timer measures how long the oldest unacknowledged packet has been waiting. When that wait exceeds a configurable limit, the block requests a replay. The same request is raised whenever the far end reports a bad packet with a negative acknowledgement. The timer restarts each time a packet finishes transmission and each time a positive acknowledgement covers a packet still held for resend. It is cleared and held while nothing is outstanding. It freezes while the physical link retrains.

A small wrapping counter records replay attempts. Each negative acknowledgement and each timer expiry adds one. An acknowledgement that shows forward progress clears it. When the counter wraps past its largest value, the block asks the physical layer to retrain the link, in the same cycle as that replay request.

All pins are plain control strobes and levels sampled on the rising clock edge. No data passes through the block, so it has no flow-controlled interface. The two outputs are registered and appear one cycle after the edge that samples their cause.

Top module: `replay_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after release, `replay_req_o` and `retrain_req_o` are 0. Reset clears the timer and the attempt counter to 0.
- R2: While `pending_i` is 0, the timer is held at 0 and no expiry occurs. When `pending_i` rises with no restart event, the first expiry is sampled TIMEOUT_CYC-1 edges after the first edge that sees `pending_i` high.
- R3: If no restart event is sampled in TIMEOUT_CYC consecutive edges after a restart, an expiry occurs and `replay_req_o` is high for exactly one cycle. The timer then restarts, so a further expiry follows TIMEOUT_CYC edges later.
- R4: `tlp_sent_i` restarts the timer from 0. A restart sampled on the very edge where expiry would occur suppresses that expiry.
- R5: `ack_i` sampled while `pending_i` is 1 restarts the timer from 0.
- R6: `nak_i` restarts the timer only when `replay_active_i` is 0. During a replay it leaves the timer running.
- R7: While `link_retrain_i` is 1 and `pending_i` is 1, the timer value does not change, and restart events are ignored. Each retraining edge therefore delays the expiry by one cycle.
- R8: `nak_i` sampled on an edge makes `replay_req_o` high after that edge, whatever the timer state.
- R9: The attempt counter is ATTEMPT_W bits wide (default 2). It adds one per edge that sees `nak_i` or an expiry. When it steps from its all-ones value back to 0, `retrain_req_o` pulses together with `replay_req_o`. With the default width this is every 4th attempt.
- R10: `fwd_prog_i` sampled together with `ack_i` or `nak_i` clears the attempt counter. If a replay trigger occurs on that same edge, the counter is set to 1 instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tlp_sent_i | input | 1 | Last symbol of a packet was sent this cycle |
| ack_i | input | 1 | Positive acknowledgement received this cycle |
| nak_i | input | 1 | Negative acknowledgement received this cycle |
| fwd_prog_i | input | 1 | The ack/nak of this cycle advanced the acknowledged sequence number |
| pending_i | input | 1 | At least one sent packet awaits acknowledgement |
| replay_active_i | input | 1 | A replay of held packets is under way |
| link_retrain_i | input | 1 | Physical link is retraining |
| replay_req_o | output | 1 | Registered pulse requesting a replay |
| retrain_req_o | output | 1 | Registered pulse requesting a link retrain |

## Verification
A timer holding a wrong count does not show at once. It shows only as a replay request that arrives early or late against the last restart, freeze or idle period, so it is visible within one timeout window at most. The bench therefore measures the exact edge of each expiry, across every restart offset and several freeze lengths. A wrong attempt count shows as a retrain pulse on the wrong replay. The bench drives sequences of eight attempts, with and without progress clears, and checks which replay carries the retrain.

// File: rtl/rpl_sup_pkg.sv
package rpl_sup_pkg;

  // Control summary handed from the top-level decode to the two engines.
  typedef struct packed {
    logic restart;   // timer restart request (before freeze/idle masking)
    logic trigger;   // replay trigger from a negative acknowledgement
    logic progress;  // acknowledged sequence number advanced
  } rpl_ctl_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/rpl_timer.sv
module rpl_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic freeze_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CW = rpl_sup_pkg::cnt_width(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  // Expiry is lost to a restart seen on the same edge, and is impossible while frozen or idle.
  always_comb expire_o = pending_i && !freeze_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!pending_i)           cnt_q <= '0;
    else if (freeze_i)             cnt_q <= cnt_q;
    else if (restart_i || expire_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_i |=> (cnt_q == '0));

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_i && !freeze_i && restart_i) |=> (cnt_q == '0));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_i && freeze_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rpl_attempts.sv
module rpl_attempts #(
  parameter int ATTEMPT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic progress_i,
  output logic wrap_o
);
  localparam logic [ATTEMPT_W-1:0] TOP = '1;
  localparam logic [ATTEMPT_W-1:0] ONE = ATTEMPT_W'(1);

  logic [ATTEMPT_W-1:0] cnt_q;

  always_comb wrap_o = evt_i && !progress_i && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (progress_i) cnt_q <= evt_i ? ONE : '0;
    else if (evt_i)      cnt_q <= cnt_q + 1'b1;
  end

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (progress_i && !evt_i) |=> (cnt_q == '0));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/replay_supervisor.sv
module replay_supervisor
  import rpl_sup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int ATTEMPT_W   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tlp_sent_i,
  input  logic ack_i,
  input  logic nak_i,
  input  logic fwd_prog_i,
  input  logic pending_i,
  input  logic replay_active_i,
  input  logic link_retrain_i,
  output logic replay_req_o,
  output logic retrain_req_o
);
  rpl_ctl_t ctl;
  logic     expire;
  logic     wrap;
  logic     attempt;
  logic     replay_q, retrain_q;

  always_comb begin
    ctl.restart  = tlp_sent_i || (ack_i && pending_i) || (nak_i && !replay_active_i);
    ctl.trigger  = nak_i;
    ctl.progress = fwd_prog_i && (ack_i || nak_i);
  end

  rpl_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending_i),
    .freeze_i  (link_retrain_i),
    .restart_i (ctl.restart),
    .expire_o  (expire)
  );

  always_comb attempt = ctl.trigger || expire;

  rpl_attempts #(.ATTEMPT_W(ATTEMPT_W)) attempts_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (attempt),
    .progress_i (ctl.progress),
    .wrap_o     (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replay_q  <= 1'b0;
      retrain_q <= 1'b0;
    end else begin
      replay_q  <= attempt;
      retrain_q <= wrap;
    end
  end

  assign replay_req_o  = replay_q;
  assign retrain_req_o = retrain_q;

  p_nak_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nak_i |=> replay_req_o);

  p_retrain_with_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req_o |-> replay_req_o);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_i && !nak_i) |=> !replay_req_o);

endmodule

// File: tb/replay_supervisor_tb.sv
module replay_supervisor_tb_top;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tlp_sent = 0, ack = 0, nak = 0, prog = 0, pending = 0, busy = 0, retrain = 0;
  logic replay_req, retrain_req;

  int checks = 0, errors = 0;
  int cyc_n = 0;
  int pe, pe_rt, last_ev, rep_now, rt_now, ev0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  replay_supervisor #(.TIMEOUT_CYC(T), .ATTEMPT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tlp_sent_i(tlp_sent), .ack_i(ack), .nak_i(nak),
    .fwd_prog_i(prog), .pending_i(pending), .replay_active_i(busy),
    .link_retrain_i(retrain), .replay_req_o(replay_req), .retrain_req_o(retrain_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic watch(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (replay_req && pe < 0) begin pe = cyc_n; pe_rt = retrain_req; end
    end
  endtask

  task automatic wait_rep(input int lim);
    for (int i = 0; i < lim && pe < 0; i++) watch(1);
  endtask

  task automatic evt(input logic t, input logic a, input logic n, input logic p);
    tlp_sent = t; ack = a; nak = n; prog = p;
    @(negedge clk);
    last_ev = cyc_n; rep_now = replay_req; rt_now = retrain_req;
    tlp_sent = 0; ack = 0; nak = 0; prog = 0;
  endtask

  // Acknowledge with progress: restarts the timer and clears the attempt count.
  task automatic clear();
    evt(0, 1, 0, 1);
    ev0 = last_ev; pe = -1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(replay_req == 0 && retrain_req == 0, "R1 in reset", replay_req + retrain_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(replay_req == 0 && retrain_req == 0, "R1 after release", replay_req + retrain_req, 0);

    // R2: idle holds timer, then first expiry after pending rises
    pe = -1; watch(4 * T);
    check(pe < 0, "R2 no expiry while idle", pe, -1);
    pending = 1;
    begin
      int p;
      p = cyc_n + 1;
      pe = -1; wait_rep(4 * T);
      check(pe == p + T - 1, "R2 first expiry edge", pe, p + T - 1);
      p = pe;
      @(negedge clk);
      check(replay_req == 0, "R3 pulse is one cycle", replay_req, 0);
      pe = -1; wait_rep(4 * T);
      check(pe == p + T, "R3 periodic expiry", pe, p + T);
    end

    // R4: packet-end restart at every offset, including the expiry edge itself
    for (int d = 1; d <= T; d++) begin
      clear();
      watch(d - 1);
      evt(1, 0, 0, 0);
      check(pe < 0 && rep_now == 0 && last_ev == ev0 + d, "R4 no early expiry", pe, -1);
      pe = -1; wait_rep(4 * T);
      check(pe == last_ev + T, "R4 expiry after restart", pe, last_ev + T);
    end

    // R5: ack while pending restarts
    for (int d = 1; d < T; d++) begin
      clear();
      watch(d - 1);
      evt(0, 1, 0, 0);
      pe = -1; wait_rep(4 * T);
      check(pe == last_ev + T, "R5 ack restart", pe, last_ev + T);
    end

    // R6 / R8: nak outside replay restarts; inside replay it does not
    clear();
    watch(2);
    evt(0, 0, 1, 0);
    check(rep_now == 1, "R8 nak replay pulse", rep_now, 1);
    pe = -1; wait_rep(4 * T);
    check(pe == last_ev + T, "R6 nak restarts timer", pe, last_ev + T);
    clear();
    busy = 1;
    watch(2);
    evt(0, 0, 1, 0);
    check(rep_now == 1, "R8 nak replay pulse in replay", rep_now, 1);
    pe = -1; wait_rep(4 * T);
    check(pe == ev0 + T, "R6 nak during replay keeps timer", pe, ev0 + T);
    busy = 0;

    // R7: retraining freezes the timer
    for (int r = 1; r <= 4; r++) begin
      clear();
      watch(1);
      retrain = 1;
      watch(r);
      retrain = 0;
      wait_rep(4 * T);
      check(pe == ev0 + T + r, "R7 freeze delays expiry", pe, ev0 + T + r);
    end

    // R9: naks count up; every fourth one wraps into a retrain
    clear();
    for (int k = 1; k <= 8; k++) begin
      evt(0, 0, 1, 0);
      check(rep_now == 1 && rt_now == ((k % 4) == 0), "R9 nak attempt wrap", rt_now, (k % 4) == 0);
    end

    // R9: expiries count too
    clear();
    for (int k = 1; k <= 4; k++) begin
      pe = -1; wait_rep(4 * T);
      check(pe > 0 && pe_rt == (k == 4), "R9 expiry attempt wrap", pe_rt, k == 4);
    end

    // R10: progress clears the count
    clear();
    for (int k = 1; k <= 3; k++) evt(0, 0, 1, 0);
    evt(0, 1, 0, 1);
    for (int k = 1; k <= 4; k++) begin
      evt(0, 0, 1, 0);
      check(rt_now == (k == 4), "R10 count cleared by ack progress", rt_now, k == 4);
    end
    clear();
    for (int k = 1; k <= 3; k++) evt(0, 0, 1, 0);
    evt(0, 0, 1, 1);
    check(rep_now == 1 && rt_now == 0, "R10 nak with progress no retrain", rt_now, 0);
    for (int k = 1; k <= 3; k++) begin
      evt(0, 0, 1, 0);
      check(rt_now == (k == 3), "R10 nak progress sets count to one", rt_now, k == 3);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule